// File: doc/BRIEF.md
# Shared-Control Event Counter Bank

This block is a memory-mapped bank of four 32-bit event counters. One 32-bit control word configures all four counters. Each counter owns one byte lane of that word, and a 5-bit event selector sits inside the lane. A counter advances by one on each clock edge where the event it has selected is active. A selector of zero turns the counter off.

Events arrive as a vector of single-cycle strobes, one strobe per event number. Event number 1 is special: it needs no strobe and counts every clock cycle. Software uses a plain 32-bit write/read port to program the control word and to preset or clear each counter's data register. The counters have no overflow indication of any kind; they simply wrap around.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, the control word and all four counters read as zero.
- R2: The control word is at byte offset 0x234. Counter n's selector occupies bits [8n+5:8n+1]. Bits 0, 6 and 7 of every byte are reserved: they read as zero and ignore writes.
- R3: A counter whose selector is zero holds its value.
- R4: Selector 1 increments the counter on every clock edge. Selectors 2 to 15 increment it on each edge where `evt_i[selector]` is high. Selectors 16 to 31 never increment it.
- R5: A counter at 0xFFFFFFFF goes to 0x00000000 on its next increment, with no other effect.
- R6: Counter n's data register is at byte offset 0x240 + 0xC*n and can be read and written. A write loads the written value. If a write and an increment land on the same edge, the write wins and the increment is dropped.
- R7: A read of any other offset returns zero. A write to any other offset changes no register.
- R8: Each counter counts only its own selected event, independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event strobes, bit k is event number k |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 12 | Byte offset for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |

## Verification
The assertions assume that `reg_we_i`, `reg_addr_i` and `evt_i` are stable around each rising edge. They also assume that these inputs are held low while reset is active, because the write-priority and step properties compare against values sampled in the previous cycle. The stimulus meets both assumptions: it changes every input only on falling edges, and it keeps them all at zero until after reset is released. Reads are sampled shortly after a falling edge, so each check sees exactly the edges counted since the last register write.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned SEL_LSB = 1;
  localparam int unsigned SEL_W   = 5;
  localparam logic [SEL_W-1:0] ID_CYCLES = 5'd1;
  localparam logic [SEL_W-1:0] ID_OFF    = 5'd0;
endpackage

// File: rtl/evtc_ctrl_reg.sv
module evtc_ctrl_reg #(
  parameter int unsigned NUM_CNT = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  import evtc_pkg::*;

  function automatic logic [DATA_W-1:0] sel_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_CNT; n++)
      for (int b = 0; b < SEL_W; b++)
        m[n*LANE_W + SEL_LSB + b] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] KEEP = sel_mask();

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i & KEEP;
  end
endmodule

// File: rtl/evtc_event_mux.sv
module evtc_event_mux #(
  parameter int unsigned NUM_EVT = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [evtc_pkg::SEL_W-1:0] sel_i,
  input  logic [NUM_EVT-1:0]         evt_i,
  output logic                       hit_o
);
  import evtc_pkg::*;
  localparam int unsigned IDX_W = $clog2(NUM_EVT);

  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx      = sel_i[IDX_W-1:0];
  assign in_range = (sel_i >> IDX_W) == '0;

  // cycles event needs no strobe; ids past the strobe vector never fire
  always_comb begin
    if (sel_i == ID_CYCLES)                 hit_o = 1'b1;
    else if (sel_i == ID_OFF || !in_range)  hit_o = 1'b0;
    else                                    hit_o = evt_i[idx];
  end

  AST_HIGH_ID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> !hit_o); // R4
endmodule

// File: rtl/evtc_counter.sv
module evtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (wr_en_i) cnt_o <= wr_data_i;   // write beats a coincident event
    else if (inc_i)   cnt_o <= cnt_o + 1'b1; // wraps silently
  end

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_o == $past(wr_data_i)); // R6
  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && inc_i) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1)); // R5
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank #(
  parameter int unsigned NUM_CNT     = 4,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_EVT     = 16,
  parameter int unsigned CTRL_OFS    = 'h234,
  parameter int unsigned DATA_BASE   = 'h240,
  parameter int unsigned DATA_STRIDE = 'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  import evtc_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  function automatic logic [DATA_W-1:0] rsvd_mask();
    logic [DATA_W-1:0] m;
    m = '1;
    for (int n = 0; n < NUM_CNT; n++)
      for (int b = 0; b < SEL_W; b++)
        m[n*LANE_W + SEL_LSB + b] = 1'b0;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] RSVD = rsvd_mask();

  logic                  ctrl_hit;
  logic [DATA_W-1:0]     ctrl_q;
  logic [NUM_CNT-1:0]    data_hit;
  logic [CNT_W-1:0]      cnt   [NUM_CNT];
  logic [DATA_W-1:0]     rd_or [NUM_CNT+1];
  logic                  hit_any;

  assign ctrl_hit = reg_addr_i == CTRL_ADDR;
  assign hit_any  = ctrl_hit | (|data_hit);

  evtc_ctrl_reg #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i & ctrl_hit),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  assign rd_or[0] = ctrl_hit ? ctrl_q : '0;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DATA_BASE + g*DATA_STRIDE);
    logic [SEL_W-1:0] sel;
    logic             inc;

    assign data_hit[g] = reg_addr_i == MY_ADDR;
    assign sel         = ctrl_q[g*LANE_W + SEL_LSB +: SEL_W];

    evtc_event_mux #(.NUM_EVT(NUM_EVT)) u_mux (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel),
      .evt_i  (evt_i),
      .hit_o  (inc)
    );

    evtc_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (reg_we_i & data_hit[g]),
      .wr_data_i (CNT_W'(reg_wdata_i)),
      .inc_i     (inc),
      .cnt_o     (cnt[g])
    );

    assign rd_or[g+1] = rd_or[g] | (data_hit[g] ? DATA_W'(cnt[g]) : '0);

    AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == ID_OFF && !(reg_we_i && data_hit[g])) |=> $stable(cnt[g])); // R3
  end

  assign reg_rdata_o = rd_or[NUM_CNT];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_any |-> reg_rdata_o == '0); // R7
  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit |-> (reg_rdata_o & RSVD) == '0); // R2
endmodule

// File: tb/evt_counter_bank_tb.sv
`timescale 1ns/1ps
module evt_counter_bank_tb;
  localparam logic [11:0] CTRL = 12'h234;
  function automatic logic [11:0] dreg(int n);
    return 12'(12'h240 + 12'hC * n);
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_counter_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // callers sit just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic t_reset();
    chk(CTRL, 32'h0, "R1");
    for (int n = 0; n < 4; n++) chk(dreg(n), 32'h0, "R1");
  endtask

  task automatic t_reserved();
    wr(CTRL, 32'hFFFF_FFFF);
    chk(CTRL, 32'h3E3E_3E3E, "R2");
    wr(CTRL, 32'h0);
    chk(CTRL, 32'h0, "R2");
    for (int n = 0; n < 4; n++) chk(dreg(n), 32'h0, "R4 high id no count");
  endtask

  task automatic t_cycles_and_off();
    wr(CTRL, 32'h0000_0002);          // counter0 sel=1
    repeat (9) @(negedge clk);
    chk(dreg(0), 32'd9, "R4 cycles");
    wr(CTRL, 32'h0);                  // last edge still counts
    repeat (5) @(negedge clk);
    chk(dreg(0), 32'd10, "R3");
    wr(dreg(0), 32'h0);
    chk(dreg(0), 32'h0, "R6 clear");
  endtask

  task automatic t_strobes();
    // counter1 sel=0xB, counter2 sel=0xD
    wr(CTRL, (32'hB << 9) | (32'hD << 17));
    evt[11] = 1'b1; evt[5] = 1'b1;
    repeat (3) @(negedge clk);
    evt[11] = 1'b0; evt[13] = 1'b1;
    repeat (4) @(negedge clk);
    evt[11] = 1'b1;
    @(negedge clk);
    evt = '0;
    repeat (2) @(negedge clk);
    chk(dreg(1), 32'd4, "R4 strobe");
    chk(dreg(2), 32'd5, "R8");
    chk(dreg(0), 32'd0, "R8");
    chk(dreg(3), 32'd0, "R8");
    wr(CTRL, 32'h0);
  endtask

  task automatic t_high_id();
    wr(CTRL, (32'h10 << 1) | (32'h1F << 25));
    evt = '1;
    repeat (6) @(negedge clk);
    evt = '0;
    chk(dreg(0), 32'd0, "R4 id16");
    chk(dreg(3), 32'd0, "R4 id31");
    wr(CTRL, 32'h0);
  endtask

  task automatic t_wrap();
    wr(dreg(2), 32'hFFFF_FFFE);
    wr(CTRL, 32'h1 << 17);
    repeat (2) @(negedge clk);
    chk(dreg(2), 32'h0, "R5");
    wr(CTRL, 32'h0);
    chk(dreg(2), 32'h1, "R5");
  endtask

  task automatic t_wr_priority();
    wr(CTRL, 32'h1 << 25);            // counter3 free-running
    repeat (3) @(negedge clk);
    wr(dreg(3), 32'h0000_1234);
    chk(dreg(3), 32'h0000_1234, "R6 priority");
    wr(CTRL, 32'h0);
    chk(dreg(3), 32'h0000_1235, "R6");
  endtask

  task automatic t_unmapped();
    wr(CTRL, 32'h0000_1A00);          // counter1 sel=0xD, idle
    wr(12'h238, 32'hDEAD_BEEF);
    wr(12'h244, 32'hDEAD_BEEF);
    wr(12'h230, 32'hDEAD_BEEF);
    chk(12'h238, 32'h0, "R7");
    chk(12'h244, 32'h0, "R7");
    chk(12'h000, 32'h0, "R7");
    chk(CTRL, 32'h0000_1A00, "R7");
    chk(dreg(1), 32'd4, "R7");
    chk(dreg(3), 32'h0000_1235, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_cycles_and_off();
    t_strobes();
    t_high_id();
    t_wrap();
    t_wr_priority();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule